// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Slave

This block stands in for the serial side of a 24-bit delta-sigma converter. It acts as a slave on a three-wire serial link: an active-low select, a serial clock driven by the master, and one data line back to the master. A test source supplies the conversion result as a parallel word, with a sign flag and an over-range flag. The block then behaves as the converter would toward the master. It runs a conversion whose length is a parameter in system clock cycles. When the conversion ends it goes to sleep by itself. While selected it reports its state on the data line, and on demand it shifts out a 32-bit result word.

The select line has two jobs. On each falling edge of select, the block samples the serial clock level to choose its clocking mode. While select is held low, the data line shows whether a conversion is still running. A readout starts on the first rising serial clock edge seen while the block is asleep and selected. The 32nd falling edge of that readout starts the next conversion. Only the mode where the master supplies the clock is modelled. If the other mode is chosen, the block raises an error flag and keeps the data line low. Select and serial clock pass through two synchronizer stages, and their edges are found in the system clock domain.

Top module: `dsAdcSerialSlave`

## Requirements
- R1: Reset selects master-clocked mode (`modeErr` = 0). Each falling edge of `csN` samples `sck`: high sets `modeErr` to 1, low clears it. `modeErr` keeps its value between falling edges of `csN`.
- R2: While `csN` is high, `sdo` is 0.
- R3: While `csN` is low, `modeErr` is 0 and no readout is in progress, `sdo` equals `busy`: 1 during a conversion, 0 once asleep.
- R4: A conversion holds `busy` high for exactly `CONV_CYCLES` clock cycles. The block then drops `busy` and sleeps, whatever the level of `csN`.
- R5: The block stays asleep until a rising `sck` edge arrives while `csN` is low. Edges on `sck` while `csN` is high leave it asleep and start no readout.
- R6: A readout sends 32 bits MSB first. Bit 31 is the end-of-conversion flag (0). Bit 30 is always 0. Bit 29 is `signPos`, bit 28 is `overRange`, bits 27:4 are `sampleValue` and bits 3:0 are `sampleSub`. The word is captured from the inputs in the cycle the conversion ends, and bit 31 is on `sdo` before the first rising `sck`.
- R7: The 32nd falling `sck` edge of a readout starts a new conversion (`busy` rises). No other event starts one after reset.
- R8: During a readout, `sdo` changes only after a detected falling `sck` edge, never after a rising one.
- R9: If `csN` rises before the 32nd falling edge, the readout is abandoned. The block stays asleep with the same result, and the next readout sends the whole word again from bit 31.
- R10: While `modeErr` is 1, `sdo` is 0 and `sck` edges start no readout.
- R11: After reset the block is in a conversion (`busy` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the master (asynchronous) |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| sampleValue | input | RES_W | Conversion result from the test source |
| sampleSub | input | SUB_W | Bits below the result LSB |
| signPos | input | 1 | Sign flag, 1 for a positive input |
| overRange | input | 1 | Over-range flag, 0 when the input is in range |
| sdo | output | 1 | Serial data to the master |
| busy | output | 1 | A conversion is in progress |
| modeErr | output | 1 | The unsupported clock mode was chosen |

## Verification
The bench builds the block with `CONV_CYCLES` = 40, which keeps each conversion short. Several full conversion, sleep and readout cycles therefore fit in one run, and the exact length of each conversion can be counted whether select is held low or high. `RES_W` and `SUB_W` keep their defaults so that the 32-bit word layout is checked bit by bit. The serial clock half-period is 5 system cycles. That is longer than the three-cycle synchronizer and edge-detect path, so every bit settles before the master samples it, and a cycle-exact model tracks `sdo`, `busy` and `modeErr` on every clock.

// File: rtl/dsAdcPkg.sv
package dsAdcPkg;

  typedef enum logic [1:0] {
    OUT_ZERO     = 2'd0,
    OUT_EOC_BUSY = 2'd1,
    OUT_EOC_IDLE = 2'd2,
    OUT_DATA     = 2'd3
  } outSel_e;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_SHIFT = 2'd2
  } state_e;

  typedef struct packed {
    logic    loadResult;
    logic    loadShift;
    logic    shiftStep;
    outSel_e outSel;
  } dpStrobe_t;

endpackage

// File: rtl/dsAdcSync.sv
module dsAdcSync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]             prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
      prevQ <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prevQ <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = ~prevQ & dout;
  assign fall = prevQ & ~dout;

endmodule

// File: rtl/dsAdcCtrl.sv
module dsAdcCtrl
  import dsAdcPkg::*;
#(
  parameter int CONV_CYCLES = 1000,
  parameter int FRAME_W     = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      csFall,
  input  logic      csRise,
  input  logic      sckS,
  input  logic      sckRise,
  input  logic      sckFall,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      modeErr
);

  localparam int CNT_W    = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W    = $clog2(FRAME_W);
  localparam int LAST_BIT = FRAME_W - 1;

  state_e           state, stateNext;
  logic [CNT_W-1:0] convCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             convDone, startRead, fallInRead, lastFall;

  assign convDone   = (state == ST_CONV) && (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign startRead  = (state == ST_SLEEP) && !csS && sckRise && !modeErr;
  assign fallInRead = (state == ST_SHIFT) && !csRise && sckFall;
  assign lastFall   = fallInRead && (bitCnt == BIT_W'(LAST_BIT));

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_CONV:  if (convDone) stateNext = ST_SLEEP;
      ST_SLEEP: if (startRead) stateNext = ST_SHIFT;
      ST_SHIFT: begin
        if (csRise)        stateNext = ST_SLEEP;
        else if (lastFall) stateNext = ST_CONV;
      end
      default:  stateNext = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CONV;
      convCnt <= '0;
      bitCnt  <= '0;
      modeErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (convDone)               convCnt <= '0;
      else if (state == ST_CONV)  convCnt <= convCnt + CNT_W'(1);
      if (startRead)              bitCnt <= '0;
      else if (fallInRead)        bitCnt <= bitCnt + BIT_W'(1);
      if (csFall)                 modeErr <= sckS;
    end
  end

  always_comb begin
    strobe.loadResult = convDone;
    strobe.loadShift  = startRead;
    strobe.shiftStep  = fallInRead && !lastFall;
    if (csS || modeErr)          strobe.outSel = OUT_ZERO;
    else if (state == ST_SHIFT)  strobe.outSel = OUT_DATA;
    else if (state == ST_CONV)   strobe.outSel = OUT_EOC_BUSY;
    else                         strobe.outSel = OUT_EOC_IDLE;
  end

  assign busy = (state == ST_CONV);

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !csFall |=> $stable(modeErr))
    else $error("modeErr changed without a select falling edge");

  assert_conv_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> (convCnt < CNT_W'(CONV_CYCLES)))
    else $error("conversion counter ran past its length");

  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP) && !(sckRise && !csS && !modeErr) |=> (state == ST_SLEEP))
    else $error("left sleep without a selected rising clock");

  assert_conv_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_CONV) && !((state == ST_SHIFT) && sckFall && !csRise &&
                             (bitCnt == BIT_W'(LAST_BIT)))
    |=> (state != ST_CONV))
    else $error("conversion started before the last falling edge");

endmodule

// File: rtl/dsAdcData.sv
module dsAdcData
  import dsAdcPkg::*;
#(
  parameter int RES_W   = 24,
  parameter int SUB_W   = 4,
  parameter int FRAME_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] sampleValue,
  input  logic [SUB_W-1:0] sampleSub,
  input  logic             signPos,
  input  logic             overRange,
  input  dpStrobe_t        strobe,
  output logic             sdo
);

  logic [FRAME_W-1:0] frameQ;
  logic [FRAME_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
      shiftQ <= '0;
    end else begin
      if (strobe.loadResult)
        frameQ <= {1'b0, 1'b0, signPos, overRange, sampleValue, sampleSub};
      if (strobe.loadShift)
        shiftQ <= frameQ;
      else if (strobe.shiftStep)
        shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
    end
  end

  always_comb begin
    unique case (strobe.outSel)
      OUT_DATA:     sdo = shiftQ[FRAME_W-1];
      OUT_EOC_BUSY: sdo = 1'b1;
      OUT_EOC_IDLE: sdo = 1'b0;
      default:      sdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsAdcSerialSlave.sv
module dsAdcSerialSlave
  import dsAdcPkg::*;
#(
  parameter int CONV_CYCLES = 1000,
  parameter int RES_W       = 24,
  parameter int SUB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sck,
  input  logic [RES_W-1:0] sampleValue,
  input  logic [SUB_W-1:0] sampleSub,
  input  logic             signPos,
  input  logic             overRange,
  output logic             sdo,
  output logic             busy,
  output logic             modeErr
);

  localparam int FRAME_W = 4 + RES_W + SUB_W;

  logic [1:0] syncOut, syncRise, syncFall;
  logic       csS, sckS, csFall, csRise, sckRise, sckFall;
  dpStrobe_t  strobe;

  dsAdcSync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) syncI (
    .clk(clk), .rstN(rstN), .din({csN, sck}),
    .dout(syncOut), .rise(syncRise), .fall(syncFall)
  );

  assign csS     = syncOut[1];
  assign sckS    = syncOut[0];
  assign csRise  = syncRise[1];
  assign csFall  = syncFall[1];
  assign sckRise = syncRise[0];
  assign sckFall = syncFall[0];

  dsAdcCtrl #(.CONV_CYCLES(CONV_CYCLES), .FRAME_W(FRAME_W)) ctrlI (
    .clk(clk), .rstN(rstN), .csS(csS), .csFall(csFall), .csRise(csRise),
    .sckS(sckS), .sckRise(sckRise), .sckFall(sckFall),
    .strobe(strobe), .busy(busy), .modeErr(modeErr)
  );

  dsAdcData #(.RES_W(RES_W), .SUB_W(SUB_W), .FRAME_W(FRAME_W)) dataI (
    .clk(clk), .rstN(rstN), .sampleValue(sampleValue), .sampleSub(sampleSub),
    .signPos(signPos), .overRange(overRange), .strobe(strobe), .sdo(sdo)
  );

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !sdo)
    else $error("sdo high while deselected");

  assert_eoc_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csS && !modeErr && (strobe.outSel != OUT_DATA)) |-> (sdo == busy))
    else $error("status bit does not follow busy");

  assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.outSel == OUT_DATA) && !sckFall && !csS) |=> (csS || $stable(sdo)))
    else $error("readout data moved without a falling clock");

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> !sdo)
    else $error("sdo driven during mode error");

endmodule

// File: tb/dsAdcSerialSlave_tb.sv
module dsAdcSerialSlave_tb_top;

  localparam int CONV = 40;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic [23:0] sampleValue = '0;
  logic [3:0]  sampleSub = '0;
  logic        signPos = 1'b0;
  logic        overRange = 1'b0;
  logic        sdo, busy, modeErr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dsAdcSerialSlave #(.CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck),
    .sampleValue(sampleValue), .sampleSub(sampleSub),
    .signPos(signPos), .overRange(overRange),
    .sdo(sdo), .busy(busy), .modeErr(modeErr)
  );

  // Behavioural reference: two-stage input delay, then the serial protocol.
  bit          mCsQ1, mCsQ2, mCsPrev, mSckQ1, mSckQ2, mSckPrev;
  int          mState;  // 0 converting, 1 asleep, 2 reading
  int          mCnt, mIdx;
  bit          mModeErr;
  logic [31:0] mFrame;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCsQ1 = 1; mCsQ2 = 1; mCsPrev = 1;
      mSckQ1 = 0; mSckQ2 = 0; mSckPrev = 0;
      mState = 0; mCnt = 0; mIdx = 0; mModeErr = 0; mFrame = '0;
    end else begin
      automatic bit s  = mCsQ2;
      automatic bit k  = mSckQ2;
      automatic bit cf = mCsPrev && !s;
      automatic bit kr = !mSckPrev && k;
      automatic bit kf = mSckPrev && !k;
      automatic bit me = mModeErr;
      if (cf) mModeErr = k;
      case (mState)
        0: if (mCnt == CONV - 1) begin
             mState = 1; mCnt = 0;
             mFrame = {2'b00, signPos, overRange, sampleValue, sampleSub};
           end else mCnt++;
        1: if (!s && kr && !me) begin mState = 2; mIdx = 0; end
        default: if (s) mState = 1;
                 else if (kf) begin
                   if (mIdx == 31) begin mState = 0; mCnt = 0; end
                   else mIdx++;
                 end
      endcase
      mCsPrev = s; mSckPrev = k;
      mCsQ2 = mCsQ1; mCsQ1 = csN;
      mSckQ2 = mSckQ1; mSckQ1 = sck;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison (covers R2, R3, R6, R8, R10 bit timing).
  always @(negedge clk) begin
    if (rstN) begin
      automatic bit expSdo = mCsQ2 ? 1'b0 : mModeErr ? 1'b0 :
                             (mState == 2) ? mFrame[31 - mIdx] : (mState == 0);
      automatic string t = mCsQ2 ? "R2 sdo" : mModeErr ? "R10 sdo" :
                           (mState == 2) ? "R6/R8 sdo" : "R3 sdo";
      check(sdo == expSdo, t, {31'b0, sdo}, {31'b0, expSdo});
      check(busy == (mState == 0), "R4 busy", {31'b0, busy}, {31'b0, mState == 0});
      check(modeErr == mModeErr, "R1 modeErr", {31'b0, modeErr}, {31'b0, mModeErr});
    end
  end

  function automatic logic [31:0] mkFrame(input logic [23:0] v, input logic [3:0] sb,
                                          input logic sg, input logic ov);
    return {2'b00, sg, ov, v, sb};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSample(input logic [23:0] v, input logic [3:0] sb,
                           input logic sg, input logic ov);
    sampleValue = v; sampleSub = sb; signPos = sg; overRange = ov;
  endtask

  task automatic readBits(input int n, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w[31 - i] = sdo;
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
      if (i != n - 1) waitClk(HALF);
    end
  endtask

  task automatic waitAsleep();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      waitClk(1);
    end
    waitClk(4);
  endtask

  task automatic measureBusy(input bit raiseCs, output int n);
    bit seen = 0;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (raiseCs && i == 4) csN = 1'b1;
      if (busy) begin n++; seen = 1; end
      else if (seen) break;
    end
  endtask

  initial begin
    logic [31:0] w;
    int n;
    setSample(24'hA5C3F0, 4'h9, 1'b1, 1'b0);
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    // R11: converting after reset; R2: deselected line low; R1: external mode
    check(busy == 1'b1, "R11 busy after reset", {31'b0, busy}, 32'd1);
    check(sdo == 1'b0, "R2 sdo deselected", {31'b0, sdo}, 32'd0);
    check(modeErr == 1'b0, "R1 reset mode", {31'b0, modeErr}, 32'd0);

    csN = 1'b0;
    waitClk(4);
    check(sdo == 1'b1, "R3 status while converting", {31'b0, sdo}, 32'd1);
    waitAsleep();
    check(sdo == 1'b0, "R3 status asleep", {31'b0, sdo}, 32'd0);

    readBits(32, w);
    setSample(24'hFFFFFF, 4'hF, 1'b0, 1'b1);
    check(w == mkFrame(24'hA5C3F0, 4'h9, 1'b1, 1'b0), "R6 frame A", w,
          mkFrame(24'hA5C3F0, 4'h9, 1'b1, 1'b0));
    measureBusy(1'b0, n);
    check(n == CONV, "R7 R4 conversion after readout, selected", n, CONV);

    // R5: clock activity while deselected is ignored
    csN = 1'b1;
    waitClk(4);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b1; waitClk(HALF); sck = 1'b0; waitClk(HALF);
    end
    check(busy == 1'b0, "R5 asleep after deselected clocks", {31'b0, busy}, 32'd0);
    csN = 1'b0;
    waitClk(4);
    check(sdo == 1'b0, "R5 still asleep when selected", {31'b0, sdo}, 32'd0);
    readBits(32, w);
    setSample(24'h000001, 4'h0, 1'b1, 1'b0);
    check(w == mkFrame(24'hFFFFFF, 4'hF, 1'b0, 1'b1), "R5 R6 frame B", w,
          mkFrame(24'hFFFFFF, 4'hF, 1'b0, 1'b1));
    measureBusy(1'b1, n);
    check(n == CONV, "R4 conversion with select high", n, CONV);

    // R9: abandoned readout
    csN = 1'b0;
    waitAsleep();
    readBits(10, w);
    check(w[31:22] == mkFrame(24'h000001, 4'h0, 1'b1, 1'b0) >> 22, "R9 partial bits",
          {22'b0, w[31:22]}, mkFrame(24'h000001, 4'h0, 1'b1, 1'b0) >> 22);
    waitClk(HALF);
    csN = 1'b1;
    waitClk(6);
    check(busy == 1'b0, "R9 no conversion after abandon", {31'b0, busy}, 32'd0);
    csN = 1'b0;
    waitClk(4);
    check(sdo == 1'b0, "R9 word restarts at bit 31", {31'b0, sdo}, 32'd0);
    readBits(32, w);
    setSample(24'h5A5A5A, 4'h6, 1'b1, 1'b1);
    check(w == mkFrame(24'h000001, 4'h0, 1'b1, 1'b0), "R9 frame C repeated", w,
          mkFrame(24'h000001, 4'h0, 1'b1, 1'b0));
    measureBusy(1'b1, n);
    check(n == CONV, "R4 R7 third conversion", n, CONV);

    // R1 / R10: unsupported mode chosen with sck high at select fall
    waitClk(4);
    sck = 1'b1;
    waitClk(4);
    csN = 1'b0;
    waitClk(5);
    check(modeErr == 1'b1, "R1 mode error set", {31'b0, modeErr}, 32'd1);
    check(sdo == 1'b0, "R10 sdo held low", {31'b0, sdo}, 32'd0);
    sck = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; waitClk(HALF); sck = 1'b0; waitClk(HALF);
    end
    check(sdo == 1'b0, "R10 clocks ignored", {31'b0, sdo}, 32'd0);
    check(busy == 1'b0, "R10 no readout completed", {31'b0, busy}, 32'd0);
    csN = 1'b1;
    waitClk(4);
    csN = 1'b0;
    waitClk(4);
    check(modeErr == 1'b0, "R1 mode error cleared", {31'b0, modeErr}, 32'd0);
    readBits(32, w);
    check(w == mkFrame(24'h5A5A5A, 4'h6, 1'b1, 1'b1), "R10 frame D intact", w,
          mkFrame(24'h5A5A5A, 4'h6, 1'b1, 1'b1));
    waitClk(6);
    check(busy == 1'b1, "R7 conversion after frame D", {31'b0, busy}, 32'd1);
    csN = 1'b1;
    waitClk(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule